// File: doc/BRIEF.md
# Adaptive Synchronization Wait Controller

This block decides how many destination-clock cycles a single-bit clock-domain-crossing signal must settle before it is used. The wait is not fixed for the worst case. The block counts metastability failures seen at two resolution times, T1 and T2, over a fixed window. The drop in failure count between the two times gives the resolution time constant. The count at T1 gives the MTBF at T1, and the block extrapolates that MTBF exponentially to every candidate wait length. It then picks the shortest wait whose MTBF still reaches a required threshold.

All of this work is done in the base-2 log domain, with no divider. A failure ratio becomes the difference of two logarithms. Each logarithm comes from a leading-one detector and a 64-entry fraction table indexed by the six bits below the leading one. Because the measurement repeats every window, the chosen wait follows slow drift in supply, temperature and data rate.

The incoming signal passes through a chain of N_TAPS flip-flops. The tap at the chosen wait length drives the output. A new wait length is adopted only at a window boundary. The output is flagged as unusable for one cycle after each change.

Top module: `sync_wait_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wait_code` is DEF_LEN−1 (wait length 2 by default), `sync_valid` is 1 and `sync_out` is 0.
- R2: `wait_code` holds the wait length minus one. `sync_out` equals `async_in` delayed by exactly (wait_code+1) rising clock edges.
- R3: For a valid window with failure counts c1 (at T1) and c2 (at T2), the chosen length is the smallest k in 1..N_TAPS for which (T2−T1)·(WIN_LOG2 − log2 c1) + (k−T1)·(log2 c1 − log2 c2) ≥ (T2−T1)·log2 `mtbf_req`. This means the extrapolated MTBF must be at or above the threshold in cycles, and equality counts as meeting it.
- R4: When no length up to N_TAPS meets the threshold, the longest length N_TAPS is chosen.
- R5: A window is invalid when c2 = 0 or c1 ≤ c2. After an invalid window the wait length stays as it was, whatever `mtbf_req` is.
- R6: The wait length changes only on the clock edge that closes a 2^WIN_LOG2-cycle window. The new value is computed from the previous complete window and the current `mtbf_req`.
- R7: `sync_valid` is 0 for exactly the one cycle after each edge where the wait length changes, and 1 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Destination clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| async_in | input | 1 | Signal from the other clock domain |
| fail_t1 | input | 1 | One-cycle strobe: a failure was detected at resolution time T1 |
| fail_t2 | input | 1 | One-cycle strobe: a failure was detected at resolution time T2 |
| mtbf_req | input | RW | Required MTBF in clock cycles |
| sync_out | output | 1 | Synchronized signal taken from the selected chain tap |
| sync_valid | output | 1 | Low in the cycle after a wait length change |
| wait_code | output | log2(N_TAPS) | Current wait length minus one |

## Verification
The assertions assume that `fail_t1` and `fail_t2` are single-cycle strobes synchronous to `clk`, and that `mtbf_req` is steady, changing at most between windows and never inside the cycle that closes a window. The stimulus drives the failure strobes as periodic patterns whose period divides the window, so every full window sees the same counts no matter where it is aligned. When the counts change, the threshold is first set so that any mixed transition window selects the same length, and `mtbf_req` changes only between settle periods. All thresholds are powers of two, so the log evaluation is exact and the boundary cases at equality are checked without rounding doubt.

// File: rtl/swc_pkg.sv
package swc_pkg;
  // fraction bits of the fixed-point log2 result
  localparam int FB = 8;
  // mantissa bits used to index the fraction table
  localparam int LB = 6;

  // fractional part of log2(1 + idx/2^LB), truncated to FB bits,
  // computed by repeated squaring in Q16
  function automatic logic [FB-1:0] frac_log2(input int idx);
    longint v;
    logic [FB-1:0] r;
    v = longint'((1 << LB) + idx) << (16 - LB);
    r = '0;
    for (int b = FB - 1; b >= 0; b--) begin
      v = (v * v) >>> 16;
      if (v >= 64'sd131072) begin
        r[b] = 1'b1;
        v = v >>> 1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/swc_log2.sv
module swc_log2 #(
  parameter int IW = 8
) (
  input  logic [IW-1:0]                     x,
  output logic [$clog2(IW)+swc_pkg::FB-1:0] y
);
  localparam int SW = $clog2(IW);
  localparam int LB = swc_pkg::LB;
  localparam int FB = swc_pkg::FB;
  localparam int NE = 1 << LB;

  logic [FB-1:0]    lut [NE];
  logic [SW-1:0]    msb;
  logic [SW-1:0]    sh;
  logic [IW+LB-1:0] ext;
  logic [LB-1:0]    idx;

  for (genvar g = 0; g < NE; g++) begin : g_lut
    assign lut[g] = swc_pkg::frac_log2(g);
  end

  always_comb begin
    msb = '0;
    for (int i = 0; i < IW; i++) begin
      if (x[i]) msb = SW'(i);
    end
    sh  = SW'(IW - 1) - msb;
    ext = {x, {LB{1'b0}}} << sh;
    idx = ext[IW+LB-2 -: LB];
    y   = {msb, lut[idx]};
  end
endmodule

// File: rtl/swc_fail_window.sv
module swc_fail_window #(
  parameter int WIN_LOG2 = 10,
  parameter int CW       = WIN_LOG2 + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fail_t1,
  input  logic          fail_t2,
  output logic          win_end,
  output logic [CW-1:0] snap_c1,
  output logic [CW-1:0] snap_c2
);
  logic [WIN_LOG2-1:0] win_q, win_d;
  logic [CW-1:0]       cnt1_q, cnt1_d, cnt2_q, cnt2_d;
  logic [CW-1:0]       tot1, tot2;

  assign win_end = &win_q;

  always_comb begin
    win_d = win_q + 1'b1;
    tot1  = cnt1_q + CW'(fail_t1);
    tot2  = cnt2_q + CW'(fail_t2);
    if (win_end) begin
      cnt1_d = '0;
      cnt2_d = '0;
    end else begin
      cnt1_d = tot1;
      cnt2_d = tot2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= '0;
      cnt1_q  <= '0;
      cnt2_q  <= '0;
      snap_c1 <= '0;
      snap_c2 <= '0;
    end else begin
      win_q  <= win_d;
      cnt1_q <= cnt1_d;
      cnt2_q <= cnt2_d;
      if (win_end) begin
        snap_c1 <= tot1;
        snap_c2 <= tot2;
      end
    end
  end
endmodule

// File: rtl/swc_wait_select.sv
module swc_wait_select #(
  parameter int N_TAPS   = 8,
  parameter int T1       = 1,
  parameter int T2       = 2,
  parameter int WIN_LOG2 = 10,
  parameter int CW       = WIN_LOG2 + 1,
  parameter int RW       = 32,
  parameter int TAPW     = $clog2(N_TAPS)
) (
  input  logic [CW-1:0]   c1,
  input  logic [CW-1:0]   c2,
  input  logic [RW-1:0]   mtbf_req,
  output logic [TAPW-1:0] sel_code,
  output logic            sel_ok
);
  localparam int FB  = swc_pkg::FB;
  localparam int DT  = T2 - T1;
  localparam int LWC = $clog2(CW) + FB;
  localparam int LWR = $clog2(RW) + FB;

  logic [LWC-1:0]    lc1, lc2;
  logic [LWR-1:0]    lrq;
  int                base, slope, target;
  logic [N_TAPS-1:0] meet;

  swc_log2 #(.IW(CW)) i_log_c1 (.x(c1),       .y(lc1));
  swc_log2 #(.IW(CW)) i_log_c2 (.x(c2),       .y(lc2));
  swc_log2 #(.IW(RW)) i_log_rq (.x(mtbf_req), .y(lrq));

  always_comb begin
    base   = DT * ((WIN_LOG2 << FB) - int'(lc1));
    slope  = int'(lc1) - int'(lc2);
    target = DT * int'(lrq);
  end

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    localparam int OFS = g + 1 - T1;
    assign meet[g] = (base + OFS * slope) >= target;
  end

  always_comb begin
    sel_code = TAPW'(N_TAPS - 1);
    for (int i = N_TAPS - 1; i >= 0; i--) begin
      if (meet[i]) sel_code = TAPW'(i);
    end
    sel_ok = (c2 != '0) && (c1 > c2);
  end
endmodule

// File: rtl/swc_sync_chain.sv
module swc_sync_chain #(
  parameter int DEPTH = 8,
  parameter int SELW  = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            d,
  input  logic [SELW-1:0] sel,
  output logic            q
);
  logic [DEPTH-1:0] stage_q, stage_d;

  always_comb begin
    stage_d = {stage_q[DEPTH-2:0], d};
    q       = stage_q[sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end
endmodule

// File: rtl/sync_wait_ctrl.sv
module sync_wait_ctrl #(
  parameter int N_TAPS   = 8,
  parameter int T1       = 1,
  parameter int T2       = 2,
  parameter int WIN_LOG2 = 10,
  parameter int RW       = 32,
  parameter int DEF_LEN  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      async_in,
  input  logic                      fail_t1,
  input  logic                      fail_t2,
  input  logic [RW-1:0]             mtbf_req,
  output logic                      sync_out,
  output logic                      sync_valid,
  output logic [$clog2(N_TAPS)-1:0] wait_code
);
  localparam int TAPW = $clog2(N_TAPS);
  localparam int CW   = WIN_LOG2 + 1;

  logic            win_end;
  logic [CW-1:0]   snap_c1, snap_c2;
  logic [TAPW-1:0] sel_code;
  logic            sel_ok;
  logic [TAPW-1:0] pend_code_q;
  logic            pend_ok_q;
  logic [TAPW-1:0] wait_q, wait_d;
  logic            blank_q, blank_d;

  swc_fail_window #(.WIN_LOG2(WIN_LOG2), .CW(CW)) i_window (
    .clk(clk), .rst_n(rst_n), .fail_t1(fail_t1), .fail_t2(fail_t2),
    .win_end(win_end), .snap_c1(snap_c1), .snap_c2(snap_c2)
  );

  swc_wait_select #(
    .N_TAPS(N_TAPS), .T1(T1), .T2(T2), .WIN_LOG2(WIN_LOG2),
    .CW(CW), .RW(RW), .TAPW(TAPW)
  ) i_select (
    .c1(snap_c1), .c2(snap_c2), .mtbf_req(mtbf_req),
    .sel_code(sel_code), .sel_ok(sel_ok)
  );

  swc_sync_chain #(.DEPTH(N_TAPS), .SELW(TAPW)) i_chain (
    .clk(clk), .rst_n(rst_n), .d(async_in), .sel(wait_q), .q(sync_out)
  );

  always_comb begin
    wait_d  = wait_q;
    blank_d = 1'b0;
    if (win_end && pend_ok_q && (pend_code_q != wait_q)) begin
      wait_d  = pend_code_q;
      blank_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_code_q <= TAPW'(DEF_LEN - 1);
      pend_ok_q   <= 1'b0;
      wait_q      <= TAPW'(DEF_LEN - 1);
      blank_q     <= 1'b0;
    end else begin
      pend_code_q <= sel_code;
      pend_ok_q   <= sel_ok;
      wait_q      <= wait_d;
      blank_q     <= blank_d;
    end
  end

  assign wait_code  = wait_q;
  assign sync_valid = ~blank_q;
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
  parameter int TAPW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [TAPW-1:0] wait_code,
  input logic            sync_valid,
  input logic            win_end,
  input logic            pend_ok
);
  AST_CHANGE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_code != $past(wait_code)) |-> $past(win_end)); // R6

  AST_CHANGE_NEEDS_VALID_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_code != $past(wait_code)) |-> $past(pend_ok)); // R5

  AST_BLANK_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_code != $past(wait_code)) |-> !sync_valid); // R7

  AST_BLANK_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_valid |-> (wait_code != $past(wait_code))); // R7
endmodule

bind sync_wait_ctrl swc_checker #(.TAPW($clog2(N_TAPS))) i_swc_checker (
  .clk(clk), .rst_n(rst_n), .wait_code(wait_code), .sync_valid(sync_valid),
  .win_end(win_end), .pend_ok(pend_ok_q)
);

// File: tb/test_sync_wait_ctrl.sv
module test_sync_wait_ctrl;
  localparam int RW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          async_in;
  logic          fail_t1, fail_t2;
  logic [RW-1:0] mtbf_req;
  logic          sync_out, sync_valid;
  logic [2:0]    wait_code;

  int errors = 0;
  int checks = 0;
  int per1 = 0;
  int per2 = 0;
  int cyc = 0;
  int lows = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sync_wait_ctrl #(.N_TAPS(8), .T1(1), .T2(2), .WIN_LOG2(6), .RW(RW), .DEF_LEN(2))
    i_sync_wait_ctrl (
      .clk(clk), .rst_n(rst_n), .async_in(async_in), .fail_t1(fail_t1),
      .fail_t2(fail_t2), .mtbf_req(mtbf_req), .sync_out(sync_out),
      .sync_valid(sync_valid), .wait_code(wait_code)
    );

  // periodic failure strobes; period divides the 64-cycle window
  always @(negedge clk) begin
    cyc     <= cyc + 1;
    fail_t1 <= (per1 != 0) && (cyc % (per1 == 0 ? 1 : per1) == 0);
    fail_t2 <= (per2 != 0) && (cyc % (per2 == 0 ? 1 : per2) == 0);
    if (rst_n && !sync_valid) lows <= lows + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // let at least three windows pass, then check code and blank cycles
  task automatic settle_and_check(input string req, input int exp_code, input int exp_lows);
    int l0;
    l0 = lows;
    repeat (260) @(negedge clk);
    check(req, int'(wait_code), exp_code);
    check("R7", lows - l0, exp_lows);
  endtask

  task automatic measure_delay(input int exp_len);
    int n;
    n = 0;
    @(negedge clk) async_in = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      n++;
      if (sync_out) break;
    end
    check("R2", n, exp_len);
    async_in = 1'b0;
    repeat (12) @(negedge clk);
    check("R2", int'(sync_out), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; async_in = 1'b0; mtbf_req = 32'd512;
    per1 = 2; per2 = 16;
    repeat (3) @(negedge clk);
    check("R1", int'(wait_code), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(wait_code), 1);
    check("R1", int'(sync_valid), 1);
    check("R1", int'(sync_out), 0);
  endtask

  // c1=32 c2=4: log2 MTBF(k) = 1 + 3(k-1)
  task automatic t_select_basic;
    settle_and_check("R3", 3, 1);      // need >= 9 -> k=4
    measure_delay(4);
  endtask

  task automatic t_select_equal;
    mtbf_req = 32'd65536;              // need >= 16, k=6 gives exactly 16
    settle_and_check("R3", 5, 1);
    measure_delay(6);
  endtask

  task automatic t_none_meets;
    mtbf_req = 32'h4000_0000;          // need >= 30, k=8 gives only 22
    settle_and_check("R4", 7, 1);
  endtask

  task automatic t_loose_req;
    mtbf_req = 32'd1;                  // need >= 0 -> k=1
    settle_and_check("R3", 0, 1);
  endtask

  task automatic t_zero_late;
    per2 = 0;                          // c2 = 0: invalid window
    settle_and_check("R5", 0, 0);
    mtbf_req = 32'h4000_0000;
    settle_and_check("R5", 0, 0);      // would be 7 if it were used
  endtask

  task automatic t_equal_counts;
    mtbf_req = 32'd1;
    per1 = 8; per2 = 8;                // c1 = c2 = 8: invalid window
    settle_and_check("R5", 0, 0);
    mtbf_req = 32'h4000_0000;
    settle_and_check("R5", 0, 0);
  endtask

  // c1=16 c2=8: log2 MTBF(k) = k + 1
  task automatic t_other_pattern;
    mtbf_req = 32'd1;
    per1 = 4; per2 = 8;
    settle_and_check("R3", 0, 0);
    mtbf_req = 32'd32;                 // need >= 5 -> k=4
    settle_and_check("R6", 3, 1);
    measure_delay(4);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_select_basic();
    t_select_equal();
    t_none_meets();
    t_loose_req();
    t_zero_late();
    t_equal_counts();
    t_other_pattern();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule